// File: doc/BRIEF.md
# Dual-Register Programmable Logic Output Cell

This block is one output cell of a sum-of-products programmable logic device. It receives product terms that an AND array has already evaluated. It folds them into two sum terms and keeps each sum term in a flip-flop of its own. It drives a three-state pin and returns three signals to the array: both register values and the pin level. Each register has its own clock and its own clear, and both come from product terms. Because of this, one register can run a buried state machine while the other register, or a combinational path, drives the pin.

The cell sits in a single synchronous clock domain. A product-term clock counts as an edge when the term is high at a system clock edge and was low at the edge before. An asynchronous clear forces the register's visible value to 0 in the same cycle and leaves the stored bit at 0 after the next edge. A static configuration word sets the options: the number of live terms in each sum, whether the two sums are combined, which path drives the pin, and the pin polarity. The system reset stands in for the clear at power-up. A preload path lets a test force both registers to chosen values.

Top module: `pld_macrocell`

## Requirements
- R1: Each sum term is the OR of its lowest N product-term bits. N is the configured count clamped into the range 4 to 8. Product-term bits at index N or above have no effect on the sum.
- R2: With `cfg_comb`=1, path A (register A input and combinational path A) carries sum A OR sum B. With `cfg_comb`=0, path A carries sum A alone. Path B always carries sum B.
- R3: A register loads its path value only at a system clock edge where its clock term is 1 and was 0 at the previous edge. At every other edge it holds its value.
- R4: While a register's clear term (`ar_pt` bit 0 for A, bit 1 for B) is 1, that register's feedback reads 0 in the same cycle. After the next edge the stored value is 0. The clear overrides a clock edge and the preset.
- R5: When `sp_pt`=1 at a register's capture edge, that register loads 1 and not its path value.
- R6: `cfg_pin_sel` picks the pin source (0 selects path A, 1 selects path B). `cfg_pin_reg`=1 selects that path's register and 0 selects its combinational sum. `cfg_inv`=1 inverts the pin value.
- R7: `pin_oe` follows `oe_pt`. `fb_pin` equals `pin_out` when the pin is enabled and equals `pin_in` when it is disabled.
- R8: `rst` clears both registers. A clock term held at 1 through reset does not count as an edge when reset is released.
- R9: With `pl_en`=1, each register loads its `pl_val` bit (bit 0 for A, bit 1 for B) at the next edge. This does not depend on the clock, clear and preset terms.
- R10: Both register feedbacks are always present on `fb_q` (bit 0 for A, bit 1 for B), whatever source is driving the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up clear |
| cfg_cnt_a | input | 4 | Live product-term count for sum A |
| cfg_cnt_b | input | 4 | Live product-term count for sum B |
| cfg_comb | input | 1 | 1: path A carries sum A OR sum B |
| cfg_pin_sel | input | 1 | Pin source path: 0 for A, 1 for B |
| cfg_pin_reg | input | 1 | 1: registered source, 0: combinational source |
| cfg_inv | input | 1 | Invert the pin value |
| pt_a | input | 8 | Product terms for sum A |
| pt_b | input | 8 | Product terms for sum B |
| ck_pt | input | 2 | Product-term clocks, bit 0 for register A |
| ar_pt | input | 2 | Product-term asynchronous clears, bit 0 for register A |
| sp_pt | input | 1 | Shared synchronous preset term |
| oe_pt | input | 1 | Output enable term |
| pl_en | input | 1 | Preload enable |
| pl_val | input | 2 | Preload values, bit 0 for register A |
| pin_in | input | 1 | Level driven onto the pad from outside |
| pin_out | output | 1 | Value driven onto the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_q | output | 2 | Register feedback to the array |
| fb_pin | output | 1 | Pin feedback to the array |

## Verification
A register that captured at the wrong edge, or missed a clear, shows up on `fb_q` one cycle after that edge, whichever source drives the pin. A wrong term mask or a wrong combine choice changes `pin_out` in the same cycle when the combinational source is selected. The bench checks every cycle against a reference model. It drives clock terms that are held high through reset, bits above the live count, a clear and a preset on the same edge, and a preload under a clear, so each of these faults shows up within one cycle of its stimulus.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int unsigned NREG = 2;
  typedef enum logic {PATH_A = 1'b0, PATH_B = 1'b1} path_e;
endpackage

// File: rtl/pld_sum_term.sv
module pld_sum_term #(
  parameter int unsigned NPT   = 8,
  parameter int unsigned MINPT = 4,
  parameter int unsigned CW    = $clog2(NPT + 1)
) (
  input  logic [NPT-1:0] pt,
  input  logic [CW-1:0]  cnt,
  output logic           sum
);
  logic [CW-1:0]  n_eff;
  logic [NPT-1:0] live;

  // clamp the configured count into the legal window
  always_comb begin
    if (cnt < CW'(MINPT))      n_eff = CW'(MINPT);
    else if (cnt > CW'(NPT))   n_eff = CW'(NPT);
    else                       n_eff = cnt;
  end

  for (genvar i = 0; i < NPT; i++) begin : g_mask
    assign live[i] = (n_eff > CW'(i));
  end

  assign sum = |(pt & live);
endmodule

// File: rtl/pld_mc_reg.sv
module pld_mc_reg (
  input  logic clk,
  input  logic rst,
  input  logic ck_term,
  input  logic ar_term,
  input  logic sp_term,
  input  logic d,
  input  logic pl_en,
  input  logic pl_val,
  output logic q_vis
);
  logic q;
  logic ck_prev;
  logic edge_hit;

  assign edge_hit = ck_term & ~ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      ck_prev <= 1'b1;   // a term held high through reset is no edge
    end else begin
      ck_prev <= ck_term;
      if (pl_en)         q <= pl_val;
      else if (ar_term)  q <= 1'b0;
      else if (edge_hit) q <= sp_term ? 1'b1 : d;
    end
  end

  // clear masks the visible value in the same cycle
  assign q_vis = q & ~ar_term;

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!pl_en && !ar_term && !edge_hit) |=> $stable(q));
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (ar_term && !pl_en) |=> (q == 1'b0));
  assert_preset_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && sp_term && !ar_term && !pl_en) |=> (q == 1'b1));
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (q == 1'b0));
  assert_preload_R9: assert property (@(posedge clk) disable iff (rst)
    pl_en |=> (q == $past(pl_val)));
endmodule

// File: rtl/pld_mc_outsel.sv
module pld_mc_outsel
  import pld_mc_pkg::*;
(
  input  logic [NREG-1:0] q_vis,
  input  logic [NREG-1:0] comb,
  input  path_e           sel,
  input  logic            reg_mode,
  input  logic            inv,
  input  logic            oe_term,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb_pin
);
  logic src;

  always_comb begin
    if (sel == PATH_B) src = reg_mode ? q_vis[1] : comb[1];
    else               src = reg_mode ? q_vis[0] : comb[0];
  end

  assign pin_out = src ^ inv;
  assign pin_oe  = oe_term;
  assign fb_pin  = oe_term ? pin_out : pin_in;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int unsigned NPT   = 8,
  parameter int unsigned MINPT = 4,
  parameter int unsigned CW    = $clog2(NPT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cfg_cnt_a,
  input  logic [CW-1:0]   cfg_cnt_b,
  input  logic            cfg_comb,
  input  logic            cfg_pin_sel,
  input  logic            cfg_pin_reg,
  input  logic            cfg_inv,
  input  logic [NPT-1:0]  pt_a,
  input  logic [NPT-1:0]  pt_b,
  input  logic [NREG-1:0] ck_pt,
  input  logic [NREG-1:0] ar_pt,
  input  logic            sp_pt,
  input  logic            oe_pt,
  input  logic            pl_en,
  input  logic [NREG-1:0] pl_val,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic [NREG-1:0] fb_q,
  output logic            fb_pin
);
  logic [NREG-1:0][NPT-1:0] pt_arr;
  logic [NREG-1:0][CW-1:0]  cnt_arr;
  logic [NREG-1:0]          sums;
  logic [NREG-1:0]          path_d;

  assign pt_arr  = {pt_b, pt_a};
  assign cnt_arr = {cfg_cnt_b, cfg_cnt_a};

  for (genvar k = 0; k < NREG; k++) begin : g_sum
    pld_sum_term #(.NPT(NPT), .MINPT(MINPT), .CW(CW)) u_sum (
      .pt  (pt_arr[k]),
      .cnt (cnt_arr[k]),
      .sum (sums[k])
    );
  end

  // path A can absorb sum B when the terms are combined
  assign path_d[0] = cfg_comb ? (sums[0] | sums[1]) : sums[0];
  assign path_d[1] = sums[1];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    pld_mc_reg u_reg (
      .clk     (clk),
      .rst     (rst),
      .ck_term (ck_pt[k]),
      .ar_term (ar_pt[k]),
      .sp_term (sp_pt),
      .d       (path_d[k]),
      .pl_en   (pl_en),
      .pl_val  (pl_val[k]),
      .q_vis   (fb_q[k])
    );
  end

  pld_mc_outsel u_out (
    .q_vis    (fb_q),
    .comb     (path_d),
    .sel      (path_e'(cfg_pin_sel)),
    .reg_mode (cfg_pin_reg),
    .inv      (cfg_inv),
    .oe_term  (oe_pt),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_pin   (fb_pin)
  );

  assert_pin_tracks_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_pin_reg && !cfg_inv) |-> (pin_out == fb_q[cfg_pin_sel]));
  assert_pin_feedback_R7: assert property (@(posedge clk) disable iff (rst)
    !oe_pt |-> (fb_pin == pin_in));
endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_cnt_a = 4'd4, cfg_cnt_b = 4'd4;
  logic       cfg_comb = 1'b0, cfg_pin_sel = 1'b0, cfg_pin_reg = 1'b0, cfg_inv = 1'b0;
  logic [7:0] pt_a = '0, pt_b = '0;
  logic [1:0] ck_pt = 2'b11, ar_pt = 2'b00, pl_val = 2'b00;
  logic       sp_pt = 1'b0, oe_pt = 1'b1, pl_en = 1'b0, pin_in = 1'b0;
  logic       pin_out, pin_oe, fb_pin;
  logic [1:0] fb_q;

  always #4 clk = ~clk;

  pld_macrocell u_dut (
    .clk(clk), .rst(rst), .cfg_cnt_a(cfg_cnt_a), .cfg_cnt_b(cfg_cnt_b),
    .cfg_comb(cfg_comb), .cfg_pin_sel(cfg_pin_sel), .cfg_pin_reg(cfg_pin_reg),
    .cfg_inv(cfg_inv), .pt_a(pt_a), .pt_b(pt_b), .ck_pt(ck_pt), .ar_pt(ar_pt),
    .sp_pt(sp_pt), .oe_pt(oe_pt), .pl_en(pl_en), .pl_val(pl_val), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_q(fb_q), .fb_pin(fb_pin)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] mq = 2'b00;
  logic [1:0] mprev = 2'b11;

  function automatic logic sum_of(input logic [7:0] pt, input logic [3:0] cnt);
    int n;
    logic s;
    n = (cnt < 4) ? 4 : ((cnt > 8) ? 8 : int'(cnt));
    s = 1'b0;
    for (int i = 0; i < n; i++) s = s | pt[i];
    return s;
  endfunction

  function automatic logic [4:0] expect_now();
    logic sa, sb, da, v0, v1, src, po;
    sa = sum_of(pt_a, cfg_cnt_a);
    sb = sum_of(pt_b, cfg_cnt_b);
    da = cfg_comb ? (sa | sb) : sa;
    v0 = ar_pt[0] ? 1'b0 : mq[0];
    v1 = ar_pt[1] ? 1'b0 : mq[1];
    src = cfg_pin_reg ? (cfg_pin_sel ? v1 : v0) : (cfg_pin_sel ? sb : da);
    po = src ^ cfg_inv;
    return {po, oe_pt, v1, v0, (oe_pt ? po : pin_in)};
  endfunction

  task automatic model_edge();
    logic sa, sb;
    logic [1:0] d;
    sa = sum_of(pt_a, cfg_cnt_a);
    sb = sum_of(pt_b, cfg_cnt_b);
    d = {sb, (cfg_comb ? (sa | sb) : sa)};
    if (rst) begin
      mq = 2'b00; mprev = 2'b11;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (pl_en)                          mq[k] = pl_val[k];
        else if (ar_pt[k])                  mq[k] = 1'b0;
        else if (ck_pt[k] && !mprev[k])     mq[k] = sp_pt ? 1'b1 : d[k];
        mprev[k] = ck_pt[k];
      end
    end
  endtask

  // driver: push this cycle's expectation, then let the edge happen
  task automatic tick(input string tag);
    exp_q.push_back(expect_now());
    tag_q.push_back(tag);
    @(posedge clk);
    model_edge();
    #1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {pin_out, pin_oe, fb_q, fb_pin};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: {pin_out,pin_oe,fb_q,fb_pin} actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(posedge clk); model_edge(); #1;
    tick("R8 reset state");
    pt_a = 8'h0F; pt_b = 8'h0F;
    tick("R8 reset with high clock terms");
    rst = 1'b0;
    tick("R8 no edge after reset release");
    tick("R8 register still clear");
    // R1 term counts on the combinational path
    cfg_pin_reg = 1'b0; ck_pt = 2'b00; pt_b = 8'h00;
    pt_a = 8'h10; cfg_cnt_a = 4'd4;  tick("R1 bit above count ignored");
    pt_a = 8'h08;                    tick("R1 top live bit");
    pt_a = 8'h80; cfg_cnt_a = 4'd8;  tick("R1 full count");
    pt_a = 8'h10; cfg_cnt_a = 4'd2;  tick("R1 count clamped up");
    pt_a = 8'h08;                    tick("R1 clamped count live bit");
    pt_a = 8'h80; cfg_cnt_a = 4'd15; tick("R1 count clamped down");
    pt_a = 8'h20; cfg_cnt_a = 4'd5;  tick("R1 count five ignores bit5");
    // R2 combined terms
    pt_a = 8'h00; pt_b = 8'h01; cfg_comb = 1'b1; tick("R2 combined path A");
    cfg_comb = 1'b0;                              tick("R2 separate path A");
    cfg_pin_sel = 1'b1;                           tick("R6 comb path B");
    cfg_inv = 1'b1;                               tick("R6 inverted");
    cfg_inv = 1'b0; cfg_pin_sel = 1'b0;
    // R3 capture on clock-term rise only
    cfg_pin_reg = 1'b1; pt_a = 8'h01;
    tick("R3 no rise no capture");
    ck_pt = 2'b01; tick("R3 rise edge");
    tick("R3 captured");
    pt_a = 8'h00; tick("R3 held high no recapture");
    ck_pt = 2'b00; tick("R3 falling no capture");
    tick("R3 held value");
    ck_pt = 2'b01; tick("R3 rise captures 0");
    tick("R3 captured 0");
    // R10 buried register B while pin shows path A comb
    cfg_pin_reg = 1'b0; pt_b = 8'h04; ck_pt = 2'b10;
    tick("R10 register B capture edge");
    ck_pt = 2'b00; tick("R10 buried B on feedback");
    // R5 preset
    pt_a = 8'h00; ck_pt = 2'b01; sp_pt = 1'b1; tick("R5 preset edge");
    sp_pt = 1'b0; ck_pt = 2'b00; tick("R5 preset loaded 1");
    // R4 clear beats preset and edge
    ar_pt = 2'b01; ck_pt = 2'b01; sp_pt = 1'b1; tick("R4 clear masks at once");
    ck_pt = 2'b00; sp_pt = 1'b0; tick("R4 still cleared");
    ar_pt = 2'b00; tick("R4 stored zero after release");
    ar_pt = 2'b10; tick("R4 clear on B only");
    ar_pt = 2'b00; tick("R4 B cleared, A kept");
    // R9 preload
    pl_en = 1'b1; pl_val = 2'b11; ar_pt = 2'b11; tick("R9 preload under clear");
    pl_en = 1'b0; ar_pt = 2'b00; tick("R9 preloaded ones");
    pl_en = 1'b1; pl_val = 2'b01; tick("R9 preload mixed");
    pl_en = 1'b0; tick("R9 preloaded mixed");
    // R7 enable and pin feedback
    cfg_pin_reg = 1'b1; oe_pt = 1'b0; pin_in = 1'b0; tick("R7 disabled pin reads input 0");
    pin_in = 1'b1; tick("R7 disabled pin reads input 1");
    oe_pt = 1'b1; tick("R7 enabled pin feeds back output");
    cfg_pin_sel = 1'b1; cfg_inv = 1'b1; tick("R6 register B inverted");
    cfg_inv = 1'b0; tick("R6 register B");
    rst = 1'b1; tick("R8 reset mid-run");
    rst = 1'b0; tick("R8 cleared after reset");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule